// File: doc/BRIEF.md
# UART Byte FIFO Pair with Trigger Requests

This block sits between a host register port and a UART serial shifter. It holds bytes the host has written until the shifter takes them, and it holds bytes the shifter has received until the host reads them. Each direction is a 64-byte first-in first-out queue. The block reports the occupancy and a full flag of both queues in one packed status word. It raises a transmit request when the transmit queue has drained to a selected level. It raises a receive request when the receive queue has filled to a selected level. Each request can be a one-cycle pulse or a held level.

The host writes with a single-cycle write strobe and reads with a single-cycle read strobe. The byte at the head of the receive queue is always presented on `rd_data`. The shifter side of the transmit path is a valid/ready stream: `tx_valid` is high while a byte is queued, and that byte leaves on any cycle where `tx_ready` is also high. The shifter may hold `tx_ready` low for as long as it needs, and nothing is lost. The receive side has no back-pressure: the shifter strobes `rx_push` once per byte. A byte that arrives while the receive queue is full is discarded and flagged as an overrun.

Each queue can be emptied by a flush command that acts once per rising edge, so the command clears itself. A receive time-out request flags bytes that have been left waiting in the queue. A bypass mode reduces each direction to a single holding register.

Top module: `uart_fifo_trig`

## Requirements
- R1: Each queue holds 64 bytes in arrival order. A host write into a full transmit queue is discarded. `tx_valid` is high whenever the transmit queue is not empty, and `tx_data` shows its oldest byte. That byte is removed on a clock edge where `tx_valid` and `tx_ready` are both high.
- R2: The status word `stat` has these fields: bits [5:0] are the receive count, bit 6 is receive full, bits [13:8] are the transmit count and bit 14 is transmit full. Bits 7 and 15 read 0. A queue holding 64 bytes shows 6'h3F in its count field with its full bit set. With fewer than 64 bytes the full bit is clear.
- R3: The transmit trigger condition is that the transmit count is less than or equal to a level picked by `tx_lvl_sel`. The levels are 0 for 2'b00, 16 for 2'b01, 32 for 2'b10 and 48 for 2'b11.
- R4: The receive trigger condition is that the receive count is greater than or equal to a level picked by `rx_lvl_sel`. The levels are 1 for 2'b00, 8 for 2'b01, 16 for 2'b10 and 32 for 2'b11.
- R5: With the style input low (pulse style), a request is high for exactly one cycle, in the cycle after the edge on which its condition became true. With the style input high (level style), the request follows the condition for as long as it holds.
- R6: A rising edge on `tx_flush` or `rx_flush` empties that queue by the next cycle. Holding the input high flushes only once, so bytes pushed while it stays high are kept.
- R7: An `rx_push` while the receive queue is full is discarded and sets `ovr_flag`. The flag stays set until an `ovr_clr` strobe. If a new overrun arrives in the same cycle as the clear, the flag stays set.
- R8: With `fifo_en` low, each direction holds a single byte. A held byte shows a count of 1 with the full bit set, and a second byte is discarded. The transmit condition is that the holding register is empty. The receive condition is that it holds a byte.
- R9: `tout_req` is high when `fifo_en` and `tout_en` are both high, the receive queue is not empty, and 3 `char_tick` pulses have passed since the last `rx_push`. It drops on the next push or when the queue becomes empty.
- R10: `rd_data` shows the oldest receive byte. An `rd_en` strobe removes it. An `rd_en` strobe on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 64-byte queues, 0: single holding registers |
| tx_lvl_sel | input | 2 | Transmit trigger level select |
| rx_lvl_sel | input | 2 | Receive trigger level select |
| tx_req_lvl | input | 1 | Transmit request style, 1 level, 0 pulse |
| rx_req_lvl | input | 1 | Receive request style, 1 level, 0 pulse |
| tout_en | input | 1 | Receive time-out enable |
| tx_flush | input | 1 | Transmit flush command, acts on its rising edge |
| rx_flush | input | 1 | Receive flush command, acts on its rising edge |
| wr_en | input | 1 | Host write strobe into the transmit queue |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe from the receive queue |
| rd_data | output | 8 | Oldest receive byte |
| stat | output | 16 | Packed counts and full flags |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_flag | output | 1 | Sticky receive overrun |
| tx_valid | output | 1 | Transmit byte available to the shifter |
| tx_ready | input | 1 | Shifter accepts the transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| char_tick | input | 1 | One pulse per character time |
| tx_req | output | 1 | Transmit request |
| rx_req | output | 1 | Receive request |
| tout_req | output | 1 | Receive time-out request |

## Verification
The only register between a strobe and every queue-derived result is the occupancy count. So `stat`, `tx_valid`, `tx_data`, `rd_data`, the level-style requests and `tout_req` change in the cycle after the edge that takes the strobe or tick, and a pulse-style request is high only in that cycle. `ovr_flag` is also set in that cycle. A flush clears its queue in the cycle after the rising edge of the command. The bench changes inputs at the falling edge and reads results at the next falling edge, so exactly one rising edge lies between a stimulus and its check. Each expected value is placed in that cycle, and a pulse is checked as gone one cycle later.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned LVL_W = 7;
  localparam int unsigned FLD_W = 6;

  // transmit threshold: request while count <= level
  function automatic logic [LVL_W-1:0] tx_level(input logic [1:0] sel);
    case (sel)
      2'b00:   tx_level = 7'd0;
      2'b01:   tx_level = 7'd16;
      2'b10:   tx_level = 7'd32;
      default: tx_level = 7'd48;
    endcase
  endfunction

  // receive threshold: request while count >= level
  function automatic logic [LVL_W-1:0] rx_level(input logic [1:0] sel);
    case (sel)
      2'b00:   rx_level = 7'd1;
      2'b01:   rx_level = 7'd8;
      2'b10:   rx_level = 7'd16;
      default: rx_level = 7'd32;
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = $clog2(DEPTH + 1),
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          one_deep,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  assign cap     = one_deep ? CW'(1) : CW'(DEPTH);
  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end
endmodule

// File: rtl/trig_req.sv
module trig_req (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic level_mode,
  output logic req
);
  logic cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign req = level_mode ? cond : (cond && !cond_q);
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
  parameter int unsigned LIMIT = 3,
  parameter int unsigned TW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic tick,
  output logic hit
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !active || restart) cnt <= '0;
    else if (tick && cnt != TW'(LIMIT)) cnt <= cnt + TW'(1);
  end

  assign hit = active && (cnt == TW'(LIMIT));
endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig #(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned TOUT_CHARS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_en,
  input  logic [1:0]  tx_lvl_sel,
  input  logic [1:0]  rx_lvl_sel,
  input  logic        tx_req_lvl,
  input  logic        rx_req_lvl,
  input  logic        tout_en,
  input  logic        tx_flush,
  input  logic        rx_flush,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic [15:0] stat,
  input  logic        ovr_clr,
  output logic        ovr_flag,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        char_tick,
  output logic        tx_req,
  output logic        rx_req,
  output logic        tout_req
);
  import uart_fifo_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_full, rx_full, tx_empty, rx_empty;
  logic             tx_fl_q, rx_fl_q, tx_fl_cmd, rx_fl_cmd;
  logic             tx_cond, rx_cond;
  logic [FLD_W-1:0] tx_fld, rx_fld;

  // flush commands act once per rising edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_fl_q <= 1'b0;
      rx_fl_q <= 1'b0;
    end else begin
      tx_fl_q <= tx_flush;
      rx_fl_q <= rx_flush;
    end
  end
  assign tx_fl_cmd = tx_flush && !tx_fl_q;
  assign rx_fl_cmd = rx_flush && !rx_fl_q;

  byte_fifo #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_fl_cmd), .one_deep(!fifo_en),
    .push(wr_en), .din(wr_data), .pop(tx_ready), .dout(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_fl_cmd), .one_deep(!fifo_en),
    .push(rx_push), .din(rx_byte), .pop(rd_en), .dout(rd_data),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign tx_valid = !tx_empty;

  // trigger conditions; bypass mode uses the holding-register meaning
  assign tx_cond = fifo_en ? (tx_cnt <= CW'(tx_level(tx_lvl_sel))) : tx_empty;
  assign rx_cond = fifo_en ? (rx_cnt >= CW'(rx_level(rx_lvl_sel))) : !rx_empty;

  trig_req u_txr (.clk(clk), .rst_n(rst_n), .cond(tx_cond),
                  .level_mode(tx_req_lvl), .req(tx_req));
  trig_req u_rxr (.clk(clk), .rst_n(rst_n), .cond(rx_cond),
                  .level_mode(rx_req_lvl), .req(rx_req));

  rx_timeout #(.LIMIT(TOUT_CHARS)) u_tout (
    .clk(clk), .rst_n(rst_n),
    .active(fifo_en && tout_en && !rx_empty),
    .restart(rx_push), .tick(char_tick), .hit(tout_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  ovr_flag <= 1'b0;
    else if (rx_push && rx_full) ovr_flag <= 1'b1;
    else if (ovr_clr)            ovr_flag <= 1'b0;
  end

  // 64 entries saturate the count field at all ones
  assign tx_fld = (tx_cnt >= CW'(DEPTH)) ? '1 : tx_cnt[FLD_W-1:0];
  assign rx_fld = (rx_cnt >= CW'(DEPTH)) ? '1 : rx_cnt[FLD_W-1:0];
  assign stat   = {1'b0, tx_full, tx_fld, 1'b0, rx_full, rx_fld};
endmodule

// File: rtl/uart_fifo_trig_chk.sv
module uart_fifo_trig_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_en,
  input logic        tout_en,
  input logic        tx_flush,
  input logic        wr_en,
  input logic        tx_ready,
  input logic        rx_push,
  input logic        rx_req_lvl,
  input logic        rd_en,
  input logic [15:0] stat,
  input logic        ovr_flag,
  input logic        rx_req,
  input logic        tout_req
);
  // R1: a write into a full transmit queue leaves it full
  a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && stat[14] && wr_en && !tx_ready && !tx_flush |=> stat[14] && stat[13:8] == 6'h3F);

  // R5: pulse style lasts one cycle
  a_r5_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_req_lvl && rx_req |=> !rx_req || rx_req_lvl);

  // R6: rising flush edge empties the transmit queue
  a_r6_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flush) |=> stat[13:8] == 6'h00 && !stat[14]);

  // R7: push into full receive queue raises overrun
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && stat[6] |=> ovr_flag);

  // R9: time-out only with queues on, enabled and data waiting
  a_r9_tout_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tout_req |-> fifo_en && tout_en && (stat[5:0] != 6'h00 || stat[6]));

  // R10: reading an empty receive queue changes nothing
  a_r10_rd_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && stat[6:0] == 7'h00 && !rx_push |=> stat[6:0] == 7'h00);
endmodule

bind uart_fifo_trig uart_fifo_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tout_en(tout_en),
  .tx_flush(tx_flush), .wr_en(wr_en), .tx_ready(tx_ready),
  .rx_push(rx_push), .rx_req_lvl(rx_req_lvl), .rd_en(rd_en),
  .stat(stat), .ovr_flag(ovr_flag), .rx_req(rx_req), .tout_req(tout_req)
);

// File: tb/sim_uart_fifo_trig.sv
module sim_uart_fifo_trig;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b1;
  logic [1:0]  tx_lvl_sel = 2'b00, rx_lvl_sel = 2'b00;
  logic        tx_req_lvl = 1'b1, rx_req_lvl = 1'b1, tout_en = 1'b0;
  logic        tx_flush = 1'b0, rx_flush = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
  logic [7:0]  wr_data = 8'h00, rx_byte = 8'h00;
  logic        tx_ready = 1'b0, rx_push = 1'b0, char_tick = 1'b0;
  logic [7:0]  rd_data, tx_data;
  logic [15:0] stat;
  logic        ovr_flag, tx_valid, tx_req, rx_req, tout_req;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  uart_fifo_trig u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_lvl_sel(tx_lvl_sel),
    .rx_lvl_sel(rx_lvl_sel), .tx_req_lvl(tx_req_lvl), .rx_req_lvl(rx_req_lvl),
    .tout_en(tout_en), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .stat(stat), .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_push(rx_push),
    .rx_byte(rx_byte), .char_tick(char_tick), .tx_req(tx_req),
    .rx_req(rx_req), .tout_req(tout_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic put_tx(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b; step(); wr_en = 1'b0;
  endtask
  task automatic put_rx(input logic [7:0] b);
    rx_push = 1'b1; rx_byte = b; step(); rx_push = 1'b0;
  endtask
  task automatic pop_tx(); tx_ready = 1'b1; step(); tx_ready = 1'b0; endtask
  task automatic pop_rx(); rd_en = 1'b1; step(); rd_en = 1'b0; endtask
  task automatic tick(); char_tick = 1'b1; step(); char_tick = 1'b0; endtask
  task automatic flush_both();
    tx_flush = 1'b1; rx_flush = 1'b1; step();
    tx_flush = 1'b0; rx_flush = 1'b0; step();
  endtask

  task automatic t_reset();
    chk("R2 reset status", stat, 16'h0000);
    chk("R3 reset tx_req at count 0", tx_req, 1'b1);
    chk("R4 reset rx_req", rx_req, 1'b0);
    chk("R1 reset tx_valid", tx_valid, 1'b0);
    chk("R7 reset ovr_flag", ovr_flag, 1'b0);
  endtask

  task automatic t_tx_fill();
    tx_lvl_sel = 2'b01;
    for (int i = 0; i < 64; i++) begin
      put_tx(8'(i));
      if (i == 15) chk("R3 tx_req at 16", tx_req, 1'b1);
      if (i == 16) chk("R3 tx_req at 17", tx_req, 1'b0);
      if (i == 62) chk("R2 63 entries not full", stat[14:8], 7'h3F);
    end
    chk("R2 tx full status", stat, 16'h7F00);
    put_tx(8'hAA);
    chk("R1 write to full dropped", stat, 16'h7F00);
    tx_ready = 1'b1;
    for (int k = 0; k < 64; k++) begin
      chk("R1 tx order", tx_data, 8'(k));
      step();
    end
    tx_ready = 1'b0;
    chk("R1 tx drained", {tx_valid, stat[14:8]}, 8'h00);
  endtask

  task automatic t_tx_levels_flush();
    for (int i = 0; i < 33; i++) put_tx(8'(i));
    tx_lvl_sel = 2'b10; step();
    chk("R3 33 above 32", tx_req, 1'b0);
    tx_lvl_sel = 2'b11; step();
    chk("R3 33 within 48", tx_req, 1'b1);
    tx_lvl_sel = 2'b00; step();
    chk("R3 33 above empty", tx_req, 1'b0);
    tx_flush = 1'b1; step();
    chk("R6 tx flushed", stat[14:8], 7'h00);
    put_tx(8'h77);
    chk("R6 held flush keeps new byte", stat[14:8], 7'h01);
    tx_flush = 1'b0; step();
    chk("R6 kept byte value", tx_data, 8'h77);
    tx_flush = 1'b1; step(); tx_flush = 1'b0;
    chk("R6 second edge flushes", stat[14:8], 7'h00);
  endtask

  task automatic t_rx();
    rx_lvl_sel = 2'b01;
    for (int i = 0; i < 7; i++) put_rx(8'h80 + 8'(i));
    chk("R4 7 below 8", rx_req, 1'b0);
    put_rx(8'h87);
    chk("R4 8 reaches 8", rx_req, 1'b1);
    rx_lvl_sel = 2'b11; step();
    chk("R4 8 below 32", rx_req, 1'b0);
    rx_lvl_sel = 2'b10; step();
    chk("R4 8 below 16", rx_req, 1'b0);
    rx_lvl_sel = 2'b00; step();
    chk("R4 8 reaches 1", rx_req, 1'b1);
    for (int i = 8; i < 64; i++) put_rx(8'h80 + 8'(i));
    chk("R2 rx full status", stat, 16'h007F);
    chk("R7 no overrun yet", ovr_flag, 1'b0);
    put_rx(8'h55);
    chk("R7 overrun set", ovr_flag, 1'b1);
    chk("R7 overrun byte dropped", stat[6:0], 7'h7F);
    chk("R10 head byte", rd_data, 8'h80);
    pop_rx();
    chk("R10 next byte", rd_data, 8'h81);
    chk("R2 63 entries", stat[6:0], 7'h3F);
    chk("R7 flag sticky", ovr_flag, 1'b1);
    ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
    chk("R7 flag cleared", ovr_flag, 1'b0);
    rx_flush = 1'b1; step(); rx_flush = 1'b0;
    chk("R6 rx flushed", stat[6:0], 7'h00);
    pop_rx();
    chk("R10 read on empty ignored", stat[6:0], 7'h00);
    put_rx(8'h3C);
    chk("R10 after empty read", {stat[6:0], rd_data}, {7'h01, 8'h3C});
    flush_both();
  endtask

  task automatic t_pulse();
    rx_lvl_sel = 2'b01; rx_req_lvl = 1'b0;
    for (int i = 0; i < 7; i++) put_rx(8'(i));
    chk("R5 pulse idle", rx_req, 1'b0);
    put_rx(8'h07);
    chk("R5 pulse high", rx_req, 1'b1);
    step();
    chk("R5 pulse gone", rx_req, 1'b0);
    rx_req_lvl = 1'b1; step(); step();
    chk("R5 level held", rx_req, 1'b1);
    flush_both();
  endtask

  task automatic t_timeout();
    tout_en = 1'b1;
    put_rx(8'h21);
    tick(); tick();
    chk("R9 two ticks", tout_req, 1'b0);
    tick();
    chk("R9 three ticks", tout_req, 1'b1);
    step();
    chk("R9 held", tout_req, 1'b1);
    put_rx(8'h22);
    chk("R9 cleared by push", tout_req, 1'b0);
    tick(); tick(); tick();
    chk("R9 fires again", tout_req, 1'b1);
    pop_rx(); pop_rx();
    chk("R9 cleared by empty", tout_req, 1'b0);
    tout_en = 1'b0;
    put_rx(8'h23);
    tick(); tick(); tick();
    chk("R9 disabled", tout_req, 1'b0);
    flush_both();
  endtask

  task automatic t_bypass();
    fifo_en = 1'b0; rx_lvl_sel = 2'b11; tx_lvl_sel = 2'b11; step();
    chk("R8 tx_req when empty", tx_req, 1'b1);
    put_tx(8'h5A);
    chk("R8 tx holding status", stat[14:8], 7'h41);
    chk("R8 tx_req off", tx_req, 1'b0);
    put_tx(8'h33);
    chk("R8 second byte dropped", tx_data, 8'h5A);
    pop_tx();
    chk("R8 tx_req back", tx_req, 1'b1);
    put_rx(8'h11);
    chk("R8 rx one byte", {rx_req, stat[6:0]}, 8'hC1);
    put_rx(8'h22);
    chk("R8 rx overrun", ovr_flag, 1'b1);
    tout_en = 1'b1;
    tick(); tick(); tick();
    chk("R9 no time-out in bypass", tout_req, 1'b0);
    chk("R8 rx held byte", rd_data, 8'h11);
    pop_rx();
    chk("R8 rx empty", {rx_req, stat[6:0]}, 8'h00);
    tout_en = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_tx_fill();
    t_tx_levels_flush();
    t_rx();
    t_pulse();
    t_timeout();
    t_bypass();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule